// File: doc/BRIEF.md
# Multidrop 9-bit UART Transmitter

This block serializes bytes onto an asynchronous serial line and can mark a character as an address in a multidrop network. The mark is the extra bit that sits after the data bits, in the slot normally used for parity. Software sets a one-shot address flag. The next byte written to the holding register then goes out with that bit at 1. Every other byte goes out with it at 0, because in multidrop operation the parity field is programmed to forced zero.

Bit timing comes from a 16x baud tick. Each bit lasts 16 ticks, and a frame starts only on a tick. There is one holding register in front of the shift stage, so a byte can wait while the previous frame is still on the line. The 9-bit enable, the address flag and the transmitter-disable bit only act while the extended-feature enable is 1. Disabling the transmitter lets the current frame finish, then holds the line idle. A waiting byte is kept and is sent once the transmitter is enabled again.

Top module: `mdrop_uart_tx`

## Requirements
- R1: After reset the line is high (idle), no frame is sent and the address flag is clear.
- R2: A frame is a low start bit, 8 data bits LSB first, an optional 9th bit, then high stop bits. Each bit lasts 16 ticks of tick16_i, and a frame begins only on a tick.
- R3: With stop2_i=0 the frame has one stop bit. With stop2_i=1 it has two. When a second byte is already waiting, its start bit follows the last stop bit of the previous frame with no gap.
- R4: par_field_i bit 0 enables the 9th bit. Bit 1 selects even (1) or odd (0) parity. Bit 2 forces the bit to the inverse of bit 1. So 111 sends 0 and 101 sends 1.
- R5: When feat_en_i=1, nine_en_i=1 and par_field_i=111, a byte written while the address flag is set is sent with its 9th bit at 1. Without the flag the 9th bit is 0.
- R6: A pulse on addr_set_i (with feat_en_i=1) sets the flag. Any holding write clears it, so the following byte is sent with its 9th bit at 0. If the write and the pulse fall in the same cycle, the write uses the old flag and the flag ends up set.
- R7: The 9th bit is latched with its byte at write time. Setting the flag after a byte is written does not change that byte.
- R8: The address flag has no effect when feat_en_i=0, when nine_en_i=0, or when par_field_i is not 111. The 9th bit then follows the R4 rule.
- R9: With feat_en_i=1 and tx_dis_i=1, a frame already on the line completes. No new frame starts and the line stays high. A written byte is held and is sent after tx_dis_i returns to 0.
- R10: tx_dis_i has no effect while feat_en_i=0.
- R11: The holding register is one entry deep. A write while it is still full replaces the waiting byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_wr_i | input | 1 | Holding-register write strobe |
| thr_data_i | input | 8 | Byte to send |
| par_field_i | input | 3 | Parity field: bit0 enable, bit1 even, bit2 forced |
| stop2_i | input | 1 | 1 selects two stop bits |
| tick16_i | input | 1 | 16x baud tick, one cycle wide |
| feat_en_i | input | 1 | Extended-feature enable |
| nine_en_i | input | 1 | 9-bit multidrop mode enable |
| addr_set_i | input | 1 | Sets the one-shot address flag |
| tx_dis_i | input | 1 | Transmitter disable |
| txd_o | output | 1 | Serial line, idle high |

## Verification
The hardest case to reach from the ports is a byte that is already latched in the holding register with a clear flag while the flag is set afterwards, because the holding register normally empties on the next tick. The bench holds the transmitter disabled to park the byte, pulses the address flag, and only then enables the transmitter. It then checks that the parked byte carries a 0 in the 9th bit and the next written byte carries a 1. Disable during a live frame and back-to-back start spacing are reached by changing inputs right after the bench detects a start bit on the line.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef struct packed {
    logic forced;
    logic even;
    logic en;
  } par_field_t;

  localparam logic [2:0] PAR_FORCED_ZERO = 3'b111;
endpackage

// File: rtl/mtx_hold.sv
module mtx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_set_i,
  input  logic              feat_en_i,
  input  logic              nine_ok_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              flag_o
);
  logic flag_q;
  logic set_en;

  assign set_en = addr_set_i & feat_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      addr_o  <= 1'b0;
    end else begin
      if (wr_i) begin
        // write consumes current flag; a same-cycle set re-arms it
        data_o  <= data_i;
        addr_o  <= flag_q & feat_en_i & nine_ok_i;
        valid_o <= 1'b1;
        flag_q  <= set_en;
      end else begin
        if (take_i) valid_o <= 1'b0;
        if (set_en) flag_q <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mtx_baud.sv
module mtx_baud #(
  parameter int TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic busy_i,
  output logic bit_end_o
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (busy_i && tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end_o = busy_i & tick_i & (cnt_q == LAST);
endmodule

// File: rtl/mtx_shift.sv
module mtx_shift #(
  parameter int DATA_W   = 8,
  parameter int MAX_STOP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              has9_i,
  input  logic              ninth_i,
  input  logic              stop2_i,
  input  logic              bit_end_i,
  output logic              busy_o,
  output logic              free_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 2 + MAX_STOP;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   left_q, len_d;
  logic               busy_q, last;

  always_comb begin
    frame_d             = '1;
    frame_d[0]          = 1'b0;
    frame_d[DATA_W:1]   = data_i;
    if (has9_i) frame_d[DATA_W+1] = ninth_i;
    len_d = CNT_W'(DATA_W + 2) + CNT_W'(has9_i) + CNT_W'(stop2_i);
  end

  assign last   = (left_q == CNT_W'(1));
  assign free_o = ~busy_q | (bit_end_i & last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      frame_q <= frame_d;
      left_q  <= len_d;
      busy_q  <= 1'b1;
    end else if (busy_q && bit_end_i) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? frame_q[0] : 1'b1;
endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx
  import mtx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TICKS    = 16,
  parameter int MAX_STOP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_wr_i,
  input  logic [DATA_W-1:0] thr_data_i,
  input  logic [2:0]        par_field_i,
  input  logic              stop2_i,
  input  logic              tick16_i,
  input  logic              feat_en_i,
  input  logic              nine_en_i,
  input  logic              addr_set_i,
  input  logic              tx_dis_i,
  output logic              txd_o
);
  par_field_t        pf;
  logic              nine_ok, dis_eff;
  logic              hold_valid, hold_addr, flag;
  logic [DATA_W-1:0] hold_data;
  logic              busy, free, load, bit_end;
  logic              par_bit, ninth;

  assign pf      = par_field_t'(par_field_i);
  assign nine_ok = nine_en_i & (par_field_i == PAR_FORCED_ZERO);
  assign dis_eff = feat_en_i & tx_dis_i;
  assign load    = hold_valid & free & ~dis_eff & tick16_i;

  always_comb begin
    if (pf.forced)    par_bit = ~pf.even;
    else if (pf.even) par_bit = ^hold_data;
    else              par_bit = ~(^hold_data);
  end

  assign ninth = par_bit | hold_addr;

  mtx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (thr_wr_i),
    .data_i     (thr_data_i),
    .addr_set_i (addr_set_i),
    .feat_en_i  (feat_en_i),
    .nine_ok_i  (nine_ok),
    .take_i     (load),
    .valid_o    (hold_valid),
    .data_o     (hold_data),
    .addr_o     (hold_addr),
    .flag_o     (flag)
  );

  mtx_baud #(.TICKS(TICKS)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .load_i    (load),
    .busy_i    (busy),
    .bit_end_o (bit_end)
  );

  mtx_shift #(.DATA_W(DATA_W), .MAX_STOP(MAX_STOP)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (hold_data),
    .has9_i    (pf.en),
    .ninth_i   (ninth),
    .stop2_i   (stop2_i),
    .bit_end_i (bit_end),
    .busy_o    (busy),
    .free_o    (free),
    .txd_o     (txd_o)
  );
endmodule

// File: rtl/mtx_chk.sv
module mtx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_o,
  input logic tick16_i,
  input logic feat_en_i,
  input logic tx_dis_i,
  input logic thr_wr_i,
  input logic addr_set_i,
  input logic busy_i,
  input logic load_i,
  input logic flag_i
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o); // R1

  AST_LOAD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> tick16_i); // R2

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !txd_o); // R2

  AST_LINE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick16_i) |=> $stable(txd_o)); // R2

  AST_FLAG_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !addr_set_i) |=> !flag_i); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_en_i && tx_dis_i) |-> !load_i); // R9
endmodule

bind mdrop_uart_tx mtx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .txd_o      (txd_o),
  .tick16_i   (tick16_i),
  .feat_en_i  (feat_en_i),
  .tx_dis_i   (tx_dis_i),
  .thr_wr_i   (thr_wr_i),
  .addr_set_i (addr_set_i),
  .busy_i     (busy),
  .load_i     (load),
  .flag_i     (flag)
);

// File: tb/mdrop_uart_tx_tb_top.sv
`timescale 1ns/1ps
module mdrop_uart_tx_tb_top;
  localparam int BIT_CLK = 64; // 16 ticks, tick every 4 clocks
  localparam int NVEC    = 12;
  // {data, par, feat, nine, flag, has9, exp_ninth}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'hA5, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h3C, 3'b011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h07, 3'b011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h07, 3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h07, 3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h81, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h81, 3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h42, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h42, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h99, 3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hFF, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, stop2 = 1'b0, tick = 1'b0;
  logic       feat = 1'b1, nine = 1'b0, aset = 1'b0, dis = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] par = '0;
  logic       txd;
  int         total = 0, fails = 0, cyc = 0, tcnt = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  mdrop_uart_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .thr_wr_i(wr), .thr_data_i(wdata),
    .par_field_i(par), .stop2_i(stop2), .tick16_i(tick), .feat_en_i(feat),
    .nine_en_i(nine), .addr_set_i(aset), .tx_dis_i(dis), .txd_o(txd)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk); aset = 1'b1;
    @(negedge clk); aset = 1'b0;
  endtask

  task automatic wait_low(output int t);
    t = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin t = cyc; break; end
    end
  endtask

  // called at the negedge where the start bit was first seen
  task automatic read_rest(input logic has9, output logic [7:0] d,
                           output logic n, output logic st, output logic sp);
    repeat (BIT_CLK/2 - 1) @(negedge clk);
    st = txd;
    for (int b = 0; b < 8; b++) begin
      repeat (BIT_CLK) @(negedge clk);
      d[b] = txd;
    end
    n = 1'b0;
    if (has9) begin
      repeat (BIT_CLK) @(negedge clk);
      n = txd;
    end
    repeat (BIT_CLK) @(negedge clk);
    sp = txd;
  endtask

  task automatic capture(input logic has9, output logic [7:0] d, output logic n,
                         output logic st, output logic sp, output logic got);
    int t;
    wait_low(t);
    got = (t >= 0);
    d = '0; n = 1'b0; st = 1'b1; sp = 1'b0;
    if (got) read_rest(has9, d, n, st, sp);
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic n, st, sp, got;
    int lows, t0, t1;

    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 line high in reset", txd, 1);
    rst_n = 1'b1;
    count_lows(200, lows);
    check("R1 idle after reset", lows, 0);

    // table walk: R2 framing, R4 parity field, R5 flag, R8 flag ignored
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      par  = VEC[v][7:5];
      feat = VEC[v][4];
      nine = VEC[v][3];
      if (VEC[v][2]) pulse_addr();
      write_byte(VEC[v][15:8]);
      capture(VEC[v][1], d, n, st, sp, got);
      check("R2 frame seen", got, 1);
      check("R2 start bit", st, 0);
      check("R2 data LSB first", d, VEC[v][15:8]);
      if (VEC[v][1]) check(VEC[v][3] | VEC[v][2] ? "R5 R8 ninth bit" : "R4 ninth bit",
                           n, VEC[v][0]);
      check("R2 stop bit", sp, 1);
    end
    feat = 1'b1; nine = 1'b0; par = 3'b000;
    repeat (200) @(negedge clk);

    // R3: back-to-back spacing with 2 and 1 stop bits
    stop2 = 1'b1;
    write_byte(8'hFF);
    wait_low(t0);
    write_byte(8'hFF);
    for (int i = 0; i < 4000 && txd == 1'b0; i++) @(negedge clk);
    wait_low(t1);
    check("R3 two stop spacing", t1 - t0, 11 * BIT_CLK);
    repeat (1500) @(negedge clk);
    stop2 = 1'b0;
    write_byte(8'hFF);
    wait_low(t0);
    write_byte(8'hFF);
    for (int i = 0; i < 4000 && txd == 1'b0; i++) @(negedge clk);
    wait_low(t1);
    check("R3 one stop spacing", t1 - t0, 10 * BIT_CLK);
    repeat (1500) @(negedge clk);

    // R9: disable mid frame, frame completes, next byte held
    write_byte(8'h5A);
    wait_low(t0);
    dis = 1'b1;
    read_rest(1'b0, d, n, st, sp);
    check("R9 live frame completes", d, 8'h5A);
    write_byte(8'h33);
    count_lows(2000, lows);
    check("R9 line idle while disabled", lows, 0);
    dis = 1'b0;
    capture(1'b0, d, n, st, sp, got);
    check("R9 held byte sent after enable", d, 8'h33);

    // R11: overwrite while held
    dis = 1'b1;
    write_byte(8'h11);
    write_byte(8'h22);
    dis = 1'b0;
    capture(1'b0, d, n, st, sp, got);
    check("R11 newest byte sent", d, 8'h22);
    count_lows(1500, lows);
    check("R11 single frame only", lows, 0);

    // R10: disable ignored without feature enable
    feat = 1'b0; dis = 1'b1;
    write_byte(8'h6E);
    capture(1'b0, d, n, st, sp, got);
    check("R10 sent despite disable", d, 8'h6E);
    feat = 1'b1; dis = 1'b0;
    repeat (200) @(negedge clk);

    // R7 latched at write, R6 self-clear, R5 address bit
    par = 3'b111; nine = 1'b1; dis = 1'b1;
    write_byte(8'h5A);
    pulse_addr();
    dis = 1'b0;
    capture(1'b1, d, n, st, sp, got);
    check("R7 queued byte data", d, 8'h5A);
    check("R7 queued byte ninth unchanged", n, 0);
    write_byte(8'h5B);
    capture(1'b1, d, n, st, sp, got);
    check("R5 address byte ninth", n, 1);
    write_byte(8'h5C);
    capture(1'b1, d, n, st, sp, got);
    check("R6 flag cleared after write", n, 0);

    // R6 same-cycle write and set: write uses old (clear), flag stays set
    @(negedge clk); wr = 1'b1; wdata = 8'h70; aset = 1'b1;
    @(negedge clk); wr = 1'b0; aset = 1'b0;
    capture(1'b1, d, n, st, sp, got);
    check("R6 same-cycle write ninth", n, 0);
    write_byte(8'h71);
    capture(1'b1, d, n, st, sp, got);
    check("R6 same-cycle flag re-armed", n, 1);

    repeat (100) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule